// File: doc/BRIEF.md
# Expansion Slot Configuration Access and Channel-Check Scanner

This block gives a host controlled access to the per-slot configuration bytes of an expansion bus with a fixed number of slots. The host opens one slot's configuration bytes in two steps. First it turns off board-level setup by writing all ones to a board setup register. Then it writes a slot number, with an enable bit, into an adapter select register. Once a slot is open, a small address window reaches the eight configuration bytes of that slot. The adapters behind the window are modelled as a register array inside the block.

A scanner, started with a single pulse, walks every slot in ascending order, one slot per clock. In each slot it tests an active-low channel-check flag held in configuration byte 5. It reports the lowest slot that fails, numbered from one. When that slot's second active-low flag says its extended status bytes are valid, the scanner also captures configuration bytes 6 and 7. If no slot fails, the scanner raises a fallback indication so that the condition can be handled by other logic. When the scan ends, the adapter select register is cleared, which closes configuration access.

Top module: `slot_cfg_scan`

## Requirements
- R1: After reset the adapter select register reads 0x00 and the board setup register reads 0x00. All configuration bytes hold 0xFF and every window read returns 0xFF. The outputs scan_busy, check_found, stat_valid and fallback_nmi are low, and check_slot, check_stat6 and check_stat7 are zero.
- R2: The host address map is as follows. Addresses 0 to 7 form the configuration window. Address 8 is the adapter select register and address 9 is the board setup register. Both registers read back the last value written to them. Bits [2:0] of the adapter select register choose the slot, so the slot number is taken modulo 8. Higher bits other than the enable bit do not change the slot.
- R3: The window reaches a slot only while the board setup register holds 0xFF and bit 3 of the adapter select register is set. At any other time a window read returns 0xFF and a window write changes no configuration byte.
- R4: Writing 0x00 to the adapter select register closes the window. Later window writes are lost, and the bytes already stored are kept.
- R5: A one-cycle pulse on scan_start while the block is idle does three things. It forces the board setup register to 0xFF, it selects slot 0 with the enable bit set, and it raises scan_busy for exactly 8 cycles. During those cycles slots 0 to 7 are selected in turn.
- R6: A slot fails when bit 7 of its configuration byte 5 is 0. After the scan, check_found is high and check_slot holds the lowest failing slot number plus one, so the range is 1 to 8.
- R7: If bit 6 of byte 5 of the reported slot is 0, stat_valid is high and check_stat6 and check_stat7 hold that slot's bytes 6 and 7. Otherwise stat_valid is low and both status outputs are zero.
- R8: When the scan completes, the adapter select register reads 0x00.
- R9: If no slot fails, fallback_nmi is high after the scan and check_found is low. All scan results stay unchanged until the next scan starts.
- R10: While scan_busy is high, host writes to the select and setup registers are ignored, and a further scan_start pulse neither restarts nor extends the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| scan_start | input | 1 | Start pulse for the channel-check scan |
| scan_busy | output | 1 | Scan in progress |
| check_found | output | 1 | A failing slot was found |
| check_slot | output | 4 | Lowest failing slot, numbered from one |
| check_stat6 | output | 8 | Captured status byte 6 |
| check_stat7 | output | 8 | Captured status byte 7 |
| stat_valid | output | 1 | Captured status bytes are valid |
| fallback_nmi | output | 1 | Scan found no failing slot |

## Verification
The bench builds the block with its default parameters: 8 slots, 8 configuration bytes per slot, the enable bit at bit 3, and the check and status flags at bits 7 and 6 of byte 5. With 8 slots, the slot numbers 1 and 8 are both reachable within one scan. This lets the bench test the lowest-wins ordering at both ends of the walk, and the wrap of a written slot number modulo 8. Because every configuration byte resets to 0xFF, which means no failure, each scenario sets up only the slots it needs, and the fallback case needs no setup at all.

// File: rtl/slotcfg_pkg.sv
package slotcfg_pkg;
   typedef enum logic [0:0] {
      SC_IDLE = 1'b0,
      SC_SCAN = 1'b1
   } scan_state_e;
endpackage

// File: rtl/slotcfg_regs.sv
module slotcfg_regs #(
   parameter int NUM_SLOTS = 8,
   parameter int POS_REGS  = 8,
   parameter int DW        = 8,
   parameter int EN_BIT    = 3,
   parameter int CHK_REG   = 5,
   parameter int CHK_BIT   = 7,
   parameter int STAT_BIT  = 6,
   parameter int STA_REG   = 6,
   parameter int STB_REG   = 7,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int IDX_W    = $clog2(POS_REGS),
   localparam int AW       = $clog2(POS_REGS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [AW-1:0]     host_addr,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   input  logic              host_block,
   input  logic              sc_adap_we,
   input  logic [DW-1:0]     sc_adap_val,
   input  logic              sc_board_off,
   input  logic [SLOT_W-1:0] sc_slot,
   output logic              sc_chk_n,
   output logic              sc_stat_n,
   output logic [DW-1:0]     sc_sta,
   output logic [DW-1:0]     sc_stb,
   output logic [DW-1:0]     adap_q,
   output logic              board_off
);
   localparam logic [AW-1:0] WIN_TOP    = AW'(POS_REGS);
   localparam logic [AW-1:0] ADAP_ADDR  = AW'(POS_REGS);
   localparam logic [AW-1:0] BOARD_ADDR = AW'(POS_REGS + 1);

   if (NUM_SLOTS != (1 << SLOT_W)) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two");
   end
   if (POS_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("POS_REGS must be a power of two");
   end
   if (EN_BIT < SLOT_W || EN_BIT >= DW) begin : g_bad_en
      $error("EN_BIT must sit above the slot field");
   end
   if (CHK_REG >= POS_REGS || STA_REG >= POS_REGS || STB_REG >= POS_REGS) begin : g_bad_idx
      $error("status byte index out of range");
   end
   if (CHK_BIT == STAT_BIT || CHK_BIT >= DW || STAT_BIT >= DW) begin : g_bad_bits
      $error("check and status flags must be distinct bits");
   end

   logic [DW-1:0]        board_q;
   logic                 open_win;
   logic                 host_ok;
   logic                 in_win;
   logic [IDX_W-1:0]     win_idx;
   logic [SLOT_W-1:0]    sel_slot;
   logic [NUM_SLOTS-1:0] chk_n_v;
   logic [NUM_SLOTS-1:0] stat_n_v;
   logic [DW-1:0]        rd_row [NUM_SLOTS];
   logic [DW-1:0]        sta_v  [NUM_SLOTS];
   logic [DW-1:0]        stb_v  [NUM_SLOTS];

   assign board_off = (board_q == '1);
   assign sel_slot  = adap_q[SLOT_W-1:0];
   assign open_win  = board_off && adap_q[EN_BIT];
   assign host_ok   = host_wr && !host_block;
   assign in_win    = (host_addr < WIN_TOP);
   assign win_idx   = host_addr[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adap_q  <= '0;
         board_q <= '0;
      end else begin
         if (sc_adap_we)
            adap_q <= sc_adap_val;
         else if (host_ok && host_addr == ADAP_ADDR)
            adap_q <= host_wdata;
         if (sc_board_off)
            board_q <= '1;
         else if (host_ok && host_addr == BOARD_ADDR)
            board_q <= host_wdata;
      end
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [DW-1:0] row [POS_REGS];
      logic          row_we;
      assign row_we = host_ok && in_win && open_win && (sel_slot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < POS_REGS; i++) row[i] <= '1;
         end else if (row_we) begin
            row[win_idx] <= host_wdata;
         end
      end
      assign rd_row[s]   = row[win_idx];
      assign chk_n_v[s]  = row[CHK_REG][CHK_BIT];
      assign stat_n_v[s] = row[CHK_REG][STAT_BIT];
      assign sta_v[s]    = row[STA_REG];
      assign stb_v[s]    = row[STB_REG];
   end

   assign sc_chk_n  = chk_n_v[sc_slot];
   assign sc_stat_n = stat_n_v[sc_slot];
   assign sc_sta    = sta_v[sc_slot];
   assign sc_stb    = stb_v[sc_slot];

   always_comb begin
      host_rdata = '1;
      if (in_win) begin
         if (open_win) host_rdata = rd_row[sel_slot];
      end else if (host_addr == ADAP_ADDR) begin
         host_rdata = adap_q;
      end else if (host_addr == BOARD_ADDR) begin
         host_rdata = board_q;
      end
   end

   // R3
   window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !open_win) |-> (host_rdata == '1));
endmodule

// File: rtl/slotcfg_scanner.sv
module slotcfg_scanner
   import slotcfg_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int DW        = 8,
   parameter int EN_BIT    = 3,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              chk_n,
   input  logic              stat_n,
   input  logic [DW-1:0]     sta,
   input  logic [DW-1:0]     stb,
   output logic [SLOT_W-1:0] idx,
   output logic              adap_we,
   output logic [DW-1:0]     adap_val,
   output logic              board_off,
   output logic              busy,
   output logic              found,
   output logic [SLOT_W:0]   found_slot,
   output logic [DW-1:0]     stat_a,
   output logic [DW-1:0]     stat_b,
   output logic              stat_ok,
   output logic              fallback
);
   localparam logic [DW-1:0]     EN_MASK = DW'(1) << EN_BIT;
   localparam logic [SLOT_W-1:0] LAST    = SLOT_W'(NUM_SLOTS - 1);

   scan_state_e state;
   logic        hit;
   logic        go;

   assign busy = (state == SC_SCAN);
   assign go   = (state == SC_IDLE) && start;
   assign hit  = busy && !chk_n;

   always_comb begin
      adap_we   = 1'b0;
      adap_val  = '0;
      board_off = 1'b0;
      if (go) begin
         adap_we   = 1'b1;
         adap_val  = EN_MASK;
         board_off = 1'b1;
      end else if (busy) begin
         adap_we  = 1'b1;
         adap_val = (idx == LAST) ? '0 : (EN_MASK | DW'(idx + 1'b1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SC_IDLE;
         idx        <= '0;
         found      <= 1'b0;
         found_slot <= '0;
         stat_a     <= '0;
         stat_b     <= '0;
         stat_ok    <= 1'b0;
         fallback   <= 1'b0;
      end else if (go) begin
         state      <= SC_SCAN;
         idx        <= '0;
         found      <= 1'b0;
         found_slot <= '0;
         stat_a     <= '0;
         stat_b     <= '0;
         stat_ok    <= 1'b0;
         fallback   <= 1'b0;
      end else if (busy) begin
         if (hit && !found) begin
            found      <= 1'b1;
            found_slot <= {1'b0, idx} + 1'b1;
            if (!stat_n) begin
               stat_a  <= sta;
               stat_b  <= stb;
               stat_ok <= 1'b1;
            end
         end
         if (idx == LAST) begin
            state    <= SC_IDLE;
            fallback <= !(found || hit);
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R7
   stat_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ok |-> found);
   // R9
   fallback_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fallback && found));
   // R6
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (found_slot >= 1 && found_slot <= (SLOT_W+1)'(NUM_SLOTS)));
   // R10
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/slot_cfg_scan.sv
module slot_cfg_scan #(
   parameter int NUM_SLOTS = 8,
   parameter int POS_REGS  = 8,
   parameter int DW        = 8,
   parameter int EN_BIT    = 3,
   parameter int CHK_REG   = 5,
   parameter int CHK_BIT   = 7,
   parameter int STAT_BIT  = 6,
   parameter int STA_REG   = 6,
   parameter int STB_REG   = 7,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int AW       = $clog2(POS_REGS + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_wr,
   input  logic [AW-1:0]   host_addr,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   input  logic            scan_start,
   output logic            scan_busy,
   output logic            check_found,
   output logic [SLOT_W:0] check_slot,
   output logic [DW-1:0]   check_stat6,
   output logic [DW-1:0]   check_stat7,
   output logic            stat_valid,
   output logic            fallback_nmi
);
   localparam logic [DW-1:0] EN_MASK = DW'(1) << EN_BIT;

   logic [SLOT_W-1:0] sc_slot;
   logic              sc_adap_we;
   logic [DW-1:0]     sc_adap_val;
   logic              sc_board_off;
   logic              sc_chk_n;
   logic              sc_stat_n;
   logic [DW-1:0]     sc_sta;
   logic [DW-1:0]     sc_stb;
   logic [DW-1:0]     adap_q;
   logic              board_off;

   slotcfg_regs #(
      .NUM_SLOTS(NUM_SLOTS), .POS_REGS(POS_REGS), .DW(DW), .EN_BIT(EN_BIT),
      .CHK_REG(CHK_REG), .CHK_BIT(CHK_BIT), .STAT_BIT(STAT_BIT),
      .STA_REG(STA_REG), .STB_REG(STB_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_block(scan_busy),
      .sc_adap_we(sc_adap_we), .sc_adap_val(sc_adap_val),
      .sc_board_off(sc_board_off), .sc_slot(sc_slot),
      .sc_chk_n(sc_chk_n), .sc_stat_n(sc_stat_n),
      .sc_sta(sc_sta), .sc_stb(sc_stb),
      .adap_q(adap_q), .board_off(board_off)
   );

   slotcfg_scanner #(
      .NUM_SLOTS(NUM_SLOTS), .DW(DW), .EN_BIT(EN_BIT)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .start(scan_start),
      .chk_n(sc_chk_n), .stat_n(sc_stat_n), .sta(sc_sta), .stb(sc_stb),
      .idx(sc_slot), .adap_we(sc_adap_we), .adap_val(sc_adap_val),
      .board_off(sc_board_off), .busy(scan_busy),
      .found(check_found), .found_slot(check_slot),
      .stat_a(check_stat6), .stat_b(check_stat7),
      .stat_ok(stat_valid), .fallback(fallback_nmi)
   );

   // R5
   scan_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> (adap_q == (EN_MASK | DW'(sc_slot))));
   // R5
   board_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> board_off);
   // R8
   close_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> (adap_q == '0));
endmodule

// File: tb/tb_slot_cfg_scan.sv
`timescale 1ns/1ps
module tb_slot_cfg_scan;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       scan_start = 1'b0;
   logic       scan_busy;
   logic       check_found;
   logic [3:0] check_slot;
   logic [7:0] check_stat6;
   logic [7:0] check_stat7;
   logic       stat_valid;
   logic       fallback_nmi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   slot_cfg_scan dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .scan_start(scan_start), .scan_busy(scan_busy),
      .check_found(check_found), .check_slot(check_slot),
      .check_stat6(check_stat6), .check_stat7(check_stat7),
      .stat_valid(stat_valid), .fallback_nmi(fallback_nmi)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic pos_set(input int slot, input int idx, input logic [7:0] d);
      hwrite(4'd9, 8'hFF);
      hwrite(4'd8, 8'h08 | 8'(slot));
      hwrite(4'(idx), d);
      hwrite(4'd8, 8'h00);
   endtask

   task automatic run_scan(input bit poke, output int cycles);
      @(negedge clk);
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      cycles = 0;
      while (scan_busy && cycles < 40) begin
         cycles++;
         if (poke && cycles == 3) begin
            scan_start = 1'b1;
            host_wr = 1'b1; host_addr = 4'd8; host_wdata = 8'h0C;
         end
         @(negedge clk);
         scan_start = 1'b0;
         host_wr = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      hread(4'd5, d); chk("R1 window", d, 8'hFF);
      hread(4'd8, d); chk("R1 adapter select", d, 8'h00);
      hread(4'd9, d); chk("R1 board setup", d, 8'h00);
      chk("R1 busy", scan_busy, 0);
      chk("R1 found", check_found, 0);
      chk("R1 fallback", fallback_nmi, 0);
      chk("R1 stat_valid", stat_valid, 0);
      chk("R1 check_slot", check_slot, 0);
   endtask

   task automatic t_gate();
      logic [7:0] d;
      hwrite(4'd8, 8'h0A);
      hread(4'd0, d); chk("R3 read with board setup active", d, 8'hFF);
      hwrite(4'd0, 8'h55);
      hwrite(4'd9, 8'hFF);
      hread(4'd0, d); chk("R3 write with board setup active lost", d, 8'hFF);
      hwrite(4'd8, 8'h02);
      hwrite(4'd0, 8'h66);
      hread(4'd0, d); chk("R3 no enable bit reads FF", d, 8'hFF);
      hwrite(4'd8, 8'h0A);
      hread(4'd0, d); chk("R3 write without enable lost", d, 8'hFF);
   endtask

   task automatic t_select();
      logic [7:0] d;
      hwrite(4'd9, 8'hFF);
      hwrite(4'd8, 8'h0B);
      hwrite(4'd1, 8'hA1);
      hread(4'd1, d); chk("R2 slot 3 byte", d, 8'hA1);
      hwrite(4'd8, 8'h1B);
      hread(4'd8, d); chk("R2 select readback", d, 8'h1B);
      hread(4'd1, d); chk("R2 slot modulo 8", d, 8'hA1);
      hwrite(4'd8, 8'h0C);
      hread(4'd1, d); chk("R2 other slot", d, 8'hFF);
      hwrite(4'd8, 8'h00);
      hread(4'd1, d); chk("R4 closed read", d, 8'hFF);
      hwrite(4'd1, 8'h77);
      hwrite(4'd8, 8'h0B);
      hread(4'd1, d); chk("R4 closed write lost", d, 8'hA1);
      hwrite(4'd8, 8'h00);
   endtask

   task automatic t_scan_stat();
      logic [7:0] d;
      int cyc;
      pos_set(2, 5, 8'h3F); pos_set(2, 6, 8'h12); pos_set(2, 7, 8'h34);
      pos_set(5, 5, 8'h7F);
      hwrite(4'd9, 8'h00);
      run_scan(1'b0, cyc);
      chk("R5 busy cycles", cyc, 8);
      hread(4'd9, d); chk("R5 board forced off", d, 8'hFF);
      hread(4'd8, d); chk("R8 select cleared", d, 8'h00);
      chk("R6 found", check_found, 1);
      chk("R6 lowest slot one-based", check_slot, 3);
      chk("R7 stat_valid", stat_valid, 1);
      chk("R7 stat6", check_stat6, 8'h12);
      chk("R7 stat7", check_stat7, 8'h34);
      chk("R9 fallback low", fallback_nmi, 0);
   endtask

   task automatic t_scan_nostat();
      logic [7:0] d;
      int cyc;
      pos_set(2, 5, 8'hFF);
      run_scan(1'b1, cyc);
      chk("R10 restart ignored", cyc, 8);
      hread(4'd8, d); chk("R10 host write ignored", d, 8'h00);
      chk("R6 next failing slot", check_slot, 6);
      chk("R7 no status", stat_valid, 0);
      chk("R7 stat6 zero", check_stat6, 0);
      chk("R7 stat7 zero", check_stat7, 0);
   endtask

   task automatic t_scan_none();
      int cyc;
      pos_set(5, 5, 8'hFF);
      pos_set(7, 5, 8'hBF);
      run_scan(1'b0, cyc);
      chk("R9 fallback", fallback_nmi, 1);
      chk("R9 no found", check_found, 0);
      repeat (5) @(negedge clk);
      chk("R9 fallback held", fallback_nmi, 1);
   endtask

   task automatic t_scan_ends();
      int cyc;
      pos_set(7, 5, 8'h3F); pos_set(7, 6, 8'hAB); pos_set(7, 7, 8'hCD);
      pos_set(0, 5, 8'h7F);
      run_scan(1'b0, cyc);
      chk("R6 slot 1 wins", check_slot, 1);
      chk("R7 slot 1 no status", stat_valid, 0);
      pos_set(0, 5, 8'hFF);
      run_scan(1'b0, cyc);
      chk("R6 last slot", check_slot, 8);
      chk("R7 last slot stat6", check_stat6, 8'hAB);
      chk("R7 last slot stat7", check_stat7, 8'hCD);
      chk("R9 fallback cleared", fallback_nmi, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_gate();
      t_select();
      t_scan_stat();
      t_scan_nostat();
      t_scan_none();
      t_scan_ends();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule